// File: doc/BRIEF.md
# Trigger Window Capture Sequencer

This block runs a ring-buffer write engine so that the memory ends up holding a window of samples around a single trigger event. A start command arms the trigger and sets the write engine running. The engine then writes continuously, wrapping inside a ring of programmable depth. Triggers are ignored until a programmed number of lead-in words has been written. The first trigger after that point captures the engine's current write address. The sequencer then lets a programmed number of trailing words through, stops the engine and disarms the trigger.

When the sequence finishes, the block presents three addresses: the captured trigger address, the first address of the window (trigger address minus the lead-in count) and the address just past the trailing words (trigger address plus the trailing count). All address arithmetic wraps modulo the ring depth, so software can read the window straight out of the ring. The lead-in count must be smaller than the ring depth. A start request that breaks this rule, or that gives a depth of zero, raises an error flag and does not start the engine.

Top module: `cwc_capture_ctrl`

## Requirements
- R1: After reset, `dma_run_o`, `trig_en_o`, `done_o`, `err_o` and `trig_addr_o` are all zero.
- R2: A start request taken while idle or done, with 0 < `ring_depth_i` and `pre_words_i` < `ring_depth_i`, makes `dma_run_o` and `trig_en_o` high and `done_o` and `err_o` low in the next cycle.
- R3: While fewer than `pre_words_i` beats (cycles with `wr_beat_i` high while running) have been counted since the start, `trig_i` is ignored and `trig_addr_o` is unchanged.
- R4: The first `trig_i` accepted after the lead-in is complete loads `trig_addr_o` with the `wr_addr_i` value of that same cycle.
- R5: After the trigger cycle, exactly `post_words_i` further beats pass. In the cycle after the last of them, `dma_run_o` and `trig_en_o` drop and `done_o` rises. With a trailing count of zero, this happens in the cycle after the trigger.
- R6: With a lead-in count of zero, a trigger in the first running cycle is accepted.
- R7: A start request with `pre_words_i` >= `ring_depth_i`, or with a depth of zero, sets `err_o`, leaves `dma_run_o` low and drops `done_o`. The next accepted start clears `err_o`.
- R8: A start request arriving while a capture is running is ignored, and the original lead-in count stays in force.
- R9: `done_o` stays high, with the engine stopped, until the next start request.
- R10: While `done_o` is high, `win_start_o` equals (trigger address − lead-in) mod depth and `win_end_o` equals (trigger address + trailing count) mod depth.
- R11: Triggers arriving after the first accepted one, during the trailing phase, do not change `trig_addr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request (one-cycle pulse) |
| pre_words_i | input | CNT_W | Lead-in word count, sampled at start |
| post_words_i | input | CNT_W | Trailing word count, sampled at start |
| ring_depth_i | input | ADDR_W+1 | Ring depth in words, sampled at start |
| wr_beat_i | input | 1 | Write engine stored one word this cycle |
| wr_addr_i | input | ADDR_W | Write engine's current ring address |
| trig_i | input | 1 | Trigger event pulse |
| dma_run_o | output | 1 | Write engine run enable |
| trig_en_o | output | 1 | Trigger source enable |
| trig_addr_o | output | ADDR_W | Captured trigger address |
| win_start_o | output | ADDR_W | First address of the capture window |
| win_end_o | output | ADDR_W | Trigger address plus trailing count, wrapped |
| done_o | output | 1 | Capture finished |
| err_o | output | 1 | Last start request was rejected |

## Verification
A sequencer stuck in the wrong phase shows up at `done_o`, one cycle off from the beat count the bench keeps on its own. The bench compares the exact number of trailing beats when `done_o` rises. A miscounted lead-in, or a trigger accepted too early, shows up at the next completion as a wrong captured address or window start, or at once as a changed `trig_addr_o` in the cycle after an early trigger. An error in the wrap arithmetic appears only in the window addresses, so the bench uses cases whose window start and end cross the ring boundary, including a trailing count longer than the ring.

// File: rtl/cwc_pkg.sv
package cwc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_PREFILL  = 3'd1,
      ST_ARMED    = 3'd2,
      ST_POSTFILL = 3'd3,
      ST_DONE     = 3'd4
   } cap_state_e;

endpackage

// File: rtl/cwc_beat_counter.sv
module cwc_beat_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             beat_i,
   input  logic [CNT_W-1:0] target_i,
   output logic             hit_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   cnt_inc;

   assign cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);
   assign hit_o   = !clr_i && beat_i && (cnt_inc == {1'b0, target_i});

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         cnt_q <= '0;
      end else if (beat_i) begin
         cnt_q <= cnt_inc[CNT_W-1:0];
      end
   end

   AST_CNT_BELOW_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && target_i != '0) |-> (cnt_q < target_i)); // R5

endmodule

// File: rtl/cwc_ring_ptr.sv
module cwc_ring_ptr #(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] load_val_i,
   input  logic              step_i,
   input  logic [ADDR_W:0]   depth_i,
   output logic [ADDR_W-1:0] ptr_o
);

   logic [ADDR_W-1:0] ptr_q;
   logic [ADDR_W:0]   ptr_inc;
   logic [ADDR_W-1:0] ptr_nxt;

   assign ptr_inc = {1'b0, ptr_q} + (ADDR_W+1)'(1);
   assign ptr_nxt = (ptr_inc >= depth_i) ? '0 : ptr_inc[ADDR_W-1:0];
   assign ptr_o   = ptr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (load_i) begin
         ptr_q <= load_val_i;
      end else if (step_i) begin
         ptr_q <= ptr_nxt;
      end
   end

   AST_PTR_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && {1'b0, ptr_q} < depth_i) |=> ({1'b0, ptr_q} < $past(depth_i))); // R10

endmodule

// File: rtl/cwc_win_base.sv
module cwc_win_base #(
   parameter int ADDR_W  = 10,
   parameter bit REG_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [ADDR_W:0]   dist_i,
   input  logic [ADDR_W:0]   depth_i,
   output logic [ADDR_W-1:0] base_o
);

   logic [ADDR_W:0]   back_sum;
   logic [ADDR_W-1:0] base_c;

   // dist_i < depth_i, so a borrow is repaired by adding one full ring
   assign back_sum = ({1'b0, addr_i} >= dist_i) ? ({1'b0, addr_i} - dist_i)
                                                : ({1'b0, addr_i} + depth_i - dist_i);
   assign base_c   = back_sum[ADDR_W-1:0];

   generate
      if (REG_OUT) begin : g_reg
         logic [ADDR_W-1:0] base_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               base_q <= '0;
            end else begin
               base_q <= base_c;
            end
         end
         assign base_o = base_q;
      end else begin : g_comb
         assign base_o = base_c;
      end
   endgenerate

endmodule

// File: rtl/cwc_capture_ctrl.sv
module cwc_capture_ctrl
   import cwc_pkg::*;
#(
   parameter int ADDR_W  = 10,
   parameter int CNT_W   = 16,
   parameter bit WIN_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CNT_W-1:0]  pre_words_i,
   input  logic [CNT_W-1:0]  post_words_i,
   input  logic [ADDR_W:0]   ring_depth_i,
   input  logic              wr_beat_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic              trig_i,
   output logic              dma_run_o,
   output logic              trig_en_o,
   output logic [ADDR_W-1:0] trig_addr_o,
   output logic [ADDR_W-1:0] win_start_o,
   output logic [ADDR_W-1:0] win_end_o,
   output logic              done_o,
   output logic              err_o
);

   localparam int CMP_W = (CNT_W > ADDR_W + 1) ? CNT_W + 1 : ADDR_W + 2;

   generate
      if (ADDR_W < 1) begin : g_bad_addr_w
         $error("cwc_capture_ctrl: ADDR_W must be at least 1");
      end
      if (CNT_W <= ADDR_W) begin : g_bad_cnt_w
         $error("cwc_capture_ctrl: CNT_W must exceed ADDR_W to hold any lead-in below the depth");
      end
   endgenerate

   cap_state_e        state_q, state_nxt;
   logic [CNT_W-1:0]  pre_q, post_q;
   logic [ADDR_W:0]   depth_q;
   logic [ADDR_W-1:0] trig_addr_q;
   logic              err_q;

   logic              can_start, cfg_bad, take_start, take_trig;
   logic              counting, cnt_hit;
   logic [CNT_W-1:0]  cnt_target;

   assign can_start  = (state_q == ST_IDLE) || (state_q == ST_DONE);
   assign cfg_bad    = (ring_depth_i == '0) ||
                       (CMP_W'(pre_words_i) >= CMP_W'(ring_depth_i));
   assign take_start = start_i && can_start;
   assign take_trig  = (state_q == ST_ARMED) && trig_i;
   assign counting   = (state_q == ST_PREFILL) || (state_q == ST_POSTFILL);
   assign cnt_target = (state_q == ST_PREFILL) ? pre_q : post_q;

   always_comb begin
      state_nxt = state_q;
      unique case (state_q)
         ST_IDLE, ST_DONE: begin
            if (start_i) begin
               if (cfg_bad)                 state_nxt = ST_IDLE;
               else if (pre_words_i == '0)  state_nxt = ST_ARMED;
               else                         state_nxt = ST_PREFILL;
            end
         end
         ST_PREFILL:  if (cnt_hit) state_nxt = ST_ARMED;
         ST_ARMED:    if (trig_i)  state_nxt = (post_q == '0) ? ST_DONE : ST_POSTFILL;
         ST_POSTFILL: if (cnt_hit) state_nxt = ST_DONE;
         default:     state_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         pre_q       <= '0;
         post_q      <= '0;
         depth_q     <= '0;
         trig_addr_q <= '0;
         err_q       <= 1'b0;
      end else begin
         state_q <= state_nxt;
         if (take_start) begin
            err_q <= cfg_bad;
            if (!cfg_bad) begin
               pre_q   <= pre_words_i;
               post_q  <= post_words_i;
               depth_q <= ring_depth_i;
            end
         end
         if (take_trig) begin
            trig_addr_q <= wr_addr_i;
         end
      end
   end

   cwc_beat_counter #(.CNT_W(CNT_W)) u_beat_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (!counting),
      .beat_i   (wr_beat_i),
      .target_i (cnt_target),
      .hit_o    (cnt_hit)
   );

   cwc_ring_ptr #(.ADDR_W(ADDR_W)) u_end_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (take_trig),
      .load_val_i (wr_addr_i),
      .step_i     ((state_q == ST_POSTFILL) && wr_beat_i),
      .depth_i    (depth_q),
      .ptr_o      (win_end_o)
   );

   cwc_win_base #(.ADDR_W(ADDR_W), .REG_OUT(WIN_REG)) u_win_base (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr_i  (trig_addr_q),
      .dist_i  (pre_q[ADDR_W:0]),
      .depth_i (depth_q),
      .base_o  (win_start_o)
   );

   assign dma_run_o   = counting || (state_q == ST_ARMED);
   assign trig_en_o   = counting || (state_q == ST_ARMED);
   assign done_o      = (state_q == ST_DONE);
   assign err_o       = err_q;
   assign trig_addr_o = trig_addr_q;

   AST_RUN_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dma_run_o) |-> $past(start_i)); // R2
   AST_PREFILL_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PREFILL) |=> $stable(trig_addr_o)); // R3
   AST_TRIG_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ARMED && trig_i) |=> (trig_addr_o == $past(wr_addr_i))); // R4
   AST_DONE_AFTER_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> ($past(trig_i) || $past(wr_beat_i))); // R5
   AST_ERR_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !dma_run_o); // R7
   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> done_o); // R9
   AST_WIN_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && $past(done_o)) |->
         ({1'b0, win_start_o} < depth_q && {1'b0, win_end_o} < depth_q)); // R10
   AST_SINGLE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_POSTFILL) |=> $stable(trig_addr_o)); // R11

endmodule

// File: tb/cwc_capture_ctrl_tb_top.sv
module cwc_capture_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 6;
   localparam int CW = 12;

   typedef struct {
      int ta;
      int ws;
      int we;
      int post;
   } exp_t;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [CW-1:0] pre_w = '0;
   logic [CW-1:0] post_w = '0;
   logic [AW:0]   depth_v = (AW+1)'(8);
   logic          beat;
   logic [AW-1:0] maddr = '0;
   logic          trig = 1'b0;
   logic          dma_run, trig_en, done, err;
   logic [AW-1:0] trig_addr, win_start, win_end;

   logic          gap_mode = 1'b0;
   logic [1:0]    gph = '0;
   int            beats_seen = 0;
   int            post_cnt = 0;
   logic          done_d = 1'b0;
   int            n_cmp = 0;
   int            n_bad = 0;
   exp_t          exp_q[$];

   cwc_capture_ctrl #(.ADDR_W(AW), .CNT_W(CW)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start),
      .pre_words_i  (pre_w),
      .post_words_i (post_w),
      .ring_depth_i (depth_v),
      .wr_beat_i    (beat),
      .wr_addr_i    (maddr),
      .trig_i       (trig),
      .dma_run_o    (dma_run),
      .trig_en_o    (trig_en),
      .trig_addr_o  (trig_addr),
      .win_start_o  (win_start),
      .win_end_o    (win_end),
      .done_o       (done),
      .err_o        (err)
   );

   // simple write engine model: one word per beat, ring address wraps at the depth
   assign beat = dma_run && (!gap_mode || gph == 2'd0);

   always @(posedge clk) begin
      gph <= gph + 2'd1;
      if (beat) begin
         maddr <= ({1'b0, maddr} + 1 >= depth_v) ? '0 : maddr + 1'b1;
         beats_seen = beats_seen + 1;
         post_cnt   = post_cnt + 1;
      end
   end

   task automatic chk(string rq, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   // monitor: pops the expected window when a capture completes
   always @(negedge clk) begin
      if (rst_n && done && !done_d) begin
         if (exp_q.size() == 0) begin
            chk("R5 unexpected done", 1, 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk("R4 trigger address", int'(trig_addr), e.ta);
            chk("R10 window start", int'(win_start), e.ws);
            chk("R10 window end", int'(win_end), e.we);
            chk("R5 trailing beats", post_cnt, e.post);
         end
      end
      done_d = done;
   end

   // driver: runs one capture and queues the window it expects
   task automatic run_cap(int pre, int post, int dep, int tdelay, bit gap, bit extra);
      int   prev_ta;
      exp_t e;
      gap_mode = gap;
      @(negedge clk);
      pre_w = CW'(pre); post_w = CW'(post); depth_v = (AW+1)'(dep);
      start = 1'b1; maddr = '0;
      @(negedge clk);
      start = 1'b0; beats_seen = 0;
      chk("R2 run", int'(dma_run), 1);
      chk("R2 trigger enable", int'(trig_en), 1);
      chk("R2 done low", int'(done), 0);
      chk("R7 err cleared", int'(err), 0);
      prev_ta = int'(trig_addr);
      if (pre > 0) begin
         // early trigger plus a restart attempt with a different lead-in
         trig = 1'b1; start = 1'b1; pre_w = '0;
         @(negedge clk);
         trig = 1'b0; start = 1'b0; pre_w = CW'(pre);
         chk("R3 early trigger ignored", int'(trig_addr), prev_ta);
         chk("R8 restart ignored", int'(dma_run), 1);
      end
      while (beats_seen < pre) @(negedge clk);
      repeat (tdelay) @(negedge clk);
      e.ta = int'(maddr);
      e.ws = (e.ta + dep - pre) % dep;
      e.we = (e.ta + post) % dep;
      e.post = post;
      exp_q.push_back(e);
      trig = 1'b1;
      @(negedge clk);
      trig = 1'b0; post_cnt = 0;
      if (extra && post > 2) begin
         trig = 1'b1;          // R11: a second trigger must not move the address
         @(negedge clk);
         trig = 1'b0;
      end
      while (!done) @(negedge clk);
      repeat (4) @(negedge clk);
      chk("R9 done held", int'(done), 1);
      chk("R9 engine stopped", int'(dma_run), 0);
      chk("R5 trigger disabled", int'(trig_en), 0);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 run", int'(dma_run), 0);
      chk("R1 trigger enable", int'(trig_en), 0);
      chk("R1 done", int'(done), 0);
      chk("R1 err", int'(err), 0);
      chk("R1 trigger address", int'(trig_addr), 0);

      run_cap(4, 6, 16, 2, 1'b0, 1'b1);
      run_cap(0, 3, 8, 0, 1'b0, 1'b0);
      chk("R6 zero lead-in trigger at first cycle", int'(trig_addr), 0);
      run_cap(7, 0, 8, 1, 1'b1, 1'b0);
      run_cap(3, 12, 5, 4, 1'b0, 1'b1);

      // rejected start: lead-in equal to depth, taken from the done state
      @(negedge clk);
      pre_w = CW'(8); depth_v = (AW+1)'(8); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R7 err on lead-in >= depth", int'(err), 1);
      chk("R7 no run", int'(dma_run), 0);
      chk("R7 done dropped", int'(done), 0);
      repeat (3) @(negedge clk);
      chk("R7 still idle", int'(dma_run), 0);

      // rejected start: zero depth
      pre_w = '0; depth_v = '0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R7 err on zero depth", int'(err), 1);
      chk("R7 no run on zero depth", int'(dma_run), 0);

      run_cap(63, 5, 64, 0, 1'b1, 1'b1);
      run_cap(2, 40, 64, 3, 1'b0, 1'b1);

      repeat (2) @(negedge clk);
      chk("R10 all windows consumed", exp_q.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule